// File: doc/BRIEF.md
# Variable-Length Memory String Engine

The engine works on strings of 24-bit words held in a single-port synchronous memory. A start pulse launches one of four operations, selected by a 2-bit code:
- compare two memory strings word by word;
- compare one memory string against a repeated constant;
- forward-copy one area to another;
- fill an area with zeros.

Each operation runs over 1 to 255 words. Addresses are 15-bit word addresses.

Every memory access goes through a request/grant handshake, so an external arbiter can stall the engine for as long as it likes. When the operation ends the engine raises a one-cycle done pulse. A compare also sets exactly one of three result flags: less, equal or greater.

A controller loads the operands, pulses start, and waits for done. A zero length is refused at once.

Top module: `strmem_engine`

## Requirements
- R1: A start with length 0 makes no memory request. In the next cycle it gives done and err both high and all result flags low.
- R2: Op code 0 compares string A (at addr_a) with string B (at addr_b) in ascending address order, reading A[i] and then B[i]. It stops at the first unequal pair and sets lt or gt from an unsigned comparison of A[i] with B[i].
- R3: A compare that finds every word equal sets eq after the last word. Word i of the string sits at base address plus i.
- R4: Op code 1 compares string A with the constant konst, one read per word. It stops at the first word that differs and sets lt when A[i] < konst and gt when A[i] > konst, both unsigned.
- R5: Op code 2 reads A[i] and then writes it to addr_b+i, in ascending i, for all len words. It touches no other word and leaves all result flags low.
- R6: Op code 3 writes zero to addr_b .. addr_b+len-1 with no reads. It leaves all result flags low.
- R7: A request holds its address, write enable and write data stable until the cycle in which mem_gnt is sampled high. Read data is taken in the cycle after that grant.
- R8: A start pulse while busy is high is ignored. The running operation and its result are unaffected, and it gives exactly one done.
- R9: done is a single-cycle pulse and busy is low in that cycle. At most one of lt, eq and gt is high, and the flags and err hold until the next accepted start, which clears them.
- R10: A length of 255 words runs to completion for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| op | input | 2 | 0 compare two, 1 compare to constant, 2 copy, 3 clear |
| addr_a | input | 15 | First string / copy source |
| addr_b | input | 15 | Second string / copy and clear destination |
| len | input | 8 | Length in words |
| konst | input | 24 | Constant for op 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| err | output | 1 | Last start had length 0 |
| res_lt | output | 1 | Compare result: less |
| res_eq | output | 1 | Compare result: equal |
| res_gt | output | 1 | Compare result: greater |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 24 | Write data |
| mem_gnt | input | 1 | Grant for the current request |
| mem_rdata | input | 24 | Read data, valid the cycle after a read grant |

## Verification
The outcome of a zero-length start is due exactly one cycle after the start edge, and the bench checks it at the falling edge in that cycle. Every other result appears together with the done pulse. That pulse comes a variable number of cycles later, because the grant input is stalled by a pseudo-random pattern or held high. The bench therefore waits for done, samples the flags at the same falling edge, and then compares memory contents and access counts against values it computes from the operands. Each operation runs under both grant patterns, over sweeps of length and mismatch position.

// File: rtl/strmem_engine.sv
module strmem_engine #(
  parameter int DW = 24,
  parameter int AW = 15,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] konst,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          res_lt,
  output logic          res_eq,
  output logic          res_gt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [1:0] OP_CMP2 = 2'd0, OP_CMPK = 2'd1, OP_COPY = 2'd2, OP_CLR = 2'd3;
  typedef enum logic [2:0] {S_IDLE, S_RA, S_DA, S_RB, S_DB, S_WR} st_t;

  st_t           st;
  logic [1:0]    op_r;
  logic [AW-1:0] pa, pb;
  logic [LW-1:0] cnt;
  logic [DW-1:0] konst_r, word_a;

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_RA) || (st == S_RB) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_RA) ? pa : pb;
  assign mem_wdata = (op_r == OP_CLR) ? '0 : word_a;

  wire          last   = (cnt == LW'(1));
  wire          cmp_on = (st == S_DB) || (st == S_DA && op_r == OP_CMPK);
  wire [DW-1:0] cx     = (st == S_DB) ? word_a : mem_rdata;
  wire [DW-1:0] cy     = (st == S_DB) ? mem_rdata : konst_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_r <= OP_CMP2; pa <= '0; pb <= '0; cnt <= '0;
      konst_r <= '0; word_a <= '0; done <= 1'b0; err <= 1'b0;
      res_lt <= 1'b0; res_eq <= 1'b0; res_gt <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          res_lt <= 1'b0; res_eq <= 1'b0; res_gt <= 1'b0;
          if (len == '0) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            err <= 1'b0; op_r <= op; pa <= addr_a; pb <= addr_b;
            cnt <= len; konst_r <= konst;
            st  <= (op == OP_CLR) ? S_WR : S_RA;
          end
        end
        S_RA: if (mem_gnt) st <= S_DA;
        S_DA: begin
          word_a <= mem_rdata;
          if (op_r == OP_CMP2) st <= S_RB;
          else if (op_r == OP_COPY) st <= S_WR;
        end
        S_RB: if (mem_gnt) st <= S_DB;
        S_WR: if (mem_gnt) begin
          if (last) begin
            st <= S_IDLE; done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1; pa <= pa + 1'b1; pb <= pb + 1'b1;
            st  <= (op_r == OP_CLR) ? S_WR : S_RA;
          end
        end
        default: ;
      endcase
      if (cmp_on) begin
        if (cx != cy) begin
          res_lt <= (cx < cy); res_gt <= (cx > cy);
          done <= 1'b1; st <= S_IDLE;
        end else if (last) begin
          res_eq <= 1'b1; done <= 1'b1; st <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1; pa <= pa + 1'b1; pb <= pb + 1'b1; st <= S_RA;
        end
      end
    end
  end

  p_zero_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len == '0) |=> (done && err && !mem_req && !busy));

  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && op_r == OP_CLR) |-> (mem_we && mem_wdata == '0));

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (!busy || ($stable(op_r) && $stable(konst_r))));

  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_lt, res_eq, res_gt}));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req) ##1 !done);
endmodule

// File: tb/strmem_engine_tb.sv
module strmem_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = '0;
  logic [14:0] addr_a = '0, addr_b = '0;
  logic [7:0] len = '0;
  logic [23:0] konst = '0;
  logic busy, done, err, res_lt, res_eq, res_gt, mem_req, mem_we, mem_gnt;
  logic [14:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  strmem_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr_a(addr_a), .addr_b(addr_b),
    .len(len), .konst(konst), .busy(busy), .done(done), .err(err), .res_lt(res_lt),
    .res_eq(res_eq), .res_gt(res_gt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata));

  logic [23:0] mem [0:511];
  logic        h_we = 1'b0;
  logic [8:0]  h_addr = '0;
  logic [23:0] h_data = '0;
  int rd_cnt = 0, wr_cnt = 0, ord_err = 0, done_cnt = 0;
  logic        have_prev = 1'b0;
  logic [14:0] prev_wa = '0;

  always @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_data;
    if (done) done_cnt <= done_cnt + 1;
    if (start && !busy) have_prev <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[8:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        if (have_prev && mem_addr != prev_wa + 15'd1) ord_err <= ord_err + 1;
        have_prev <= 1'b1;
        prev_wa <= mem_addr;
      end else begin
        mem_rdata <= mem[mem_addr[8:0]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  logic        full_gnt = 1'b1;
  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_gnt <= full_gnt | lfsr[0];
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [23:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a[8:0]; h_data = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  int r0, w0, o0, d0;
  // launch and wait for done; returns cycles from start edge to done
  task automatic run(input logic [1:0] o, input int a, input int b, input int l,
                     input logic [23:0] k, output int cyc);
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt; o0 = ord_err; d0 = done_cnt;
    op = o; addr_a = a[14:0]; addr_b = b[14:0]; len = l[7:0]; konst = k; start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
  endtask

  function automatic [2:0] flags(); return {res_lt, res_eq, res_gt}; endfunction

  task automatic suite;
    int cyc, lens[4], np;
    logic [23:0] av, bv, ks;
    // R1 zero length for every op, then err cleared by next accepted start (R9)
    for (int o = 0; o < 4; o++) begin
      run(o[1:0], 0, 256, 0, 24'h1, cyc);
      chk(cyc == 1 && done && err && flags() == 3'b000, "R1", cyc, 1);
      chk(rd_cnt == r0 && wr_cnt == w0, "R1", rd_cnt + wr_cnt - r0 - w0, 0);
    end
    // R2/R3 two-string compare sweep
    lens = '{1, 3, 8, 255};
    for (int li = 0; li < 4; li++) begin
      for (int i = 0; i < lens[li]; i++) begin
        poke(i, 24'(1000 + 7 * i)); poke(256 + i, 24'(1000 + 7 * i));
      end
      for (int p = 0; p <= lens[li]; p += (lens[li] > 8 ? 51 : 1)) begin
        for (int s = 0; s < 2; s++) begin
          if (p < lens[li]) poke(256 + p, 24'(1000 + 7 * p + (s ? 1 : -1)));
          run(2'd0, 0, 256, lens[li], 24'h0, cyc);
          np = (p < lens[li]) ? p + 1 : lens[li];
          if (p < lens[li])
            chk(done && !err && flags() == (s ? 3'b100 : 3'b001), "R2", flags(), s ? 4 : 1);
          else
            chk(done && !err && flags() == 3'b010, lens[li] == 255 ? "R3 R10" : "R3", flags(), 2);
          chk(rd_cnt - r0 == 2 * np && wr_cnt == w0, "R2", rd_cnt - r0, 2 * np);
          if (p < lens[li]) poke(256 + p, 24'(1000 + 7 * p));
        end
      end
    end
    // R4 compare with constant, including an unsigned-only case
    lens = '{1, 4, 255, 2};
    for (int li = 0; li < 4; li++) begin
      ks = (li == 3) ? 24'h000001 : 24'h800000;
      for (int i = 0; i < lens[li]; i++) poke(i, ks);
      for (int p = 0; p <= lens[li]; p += (lens[li] > 8 ? 85 : 1)) begin
        for (int s = 0; s < 2; s++) begin
          av = (li == 3) ? (s ? 24'hFFFFFF : 24'h000000) : (s ? ks + 24'd1 : ks - 24'd1);
          if (p < lens[li]) poke(p, av);
          run(2'd1, 0, 0, lens[li], ks, cyc);
          np = (p < lens[li]) ? p + 1 : lens[li];
          if (p < lens[li])
            chk(flags() == (av > ks ? 3'b001 : 3'b100), "R4", flags(), av > ks ? 1 : 4);
          else
            chk(flags() == 3'b010, "R4 R3", flags(), 2);
          chk(rd_cnt - r0 == np && wr_cnt == w0, "R4", rd_cnt - r0, np);
          if (p < lens[li]) poke(p, ks);
        end
      end
    end
    // R5 copy
    lens = '{1, 2, 17, 255};
    for (int li = 0; li < 4; li++) begin
      for (int i = 0; i < 256; i++) begin poke(i, 24'(13 * i + 5)); poke(256 + i, 24'hABCDEF); end
      run(2'd2, 0, 256, lens[li], 24'h0, cyc);
      chk(done && flags() == 3'b000 && !err, "R5", flags(), 0);
      chk(rd_cnt - r0 == lens[li] && wr_cnt - w0 == lens[li] && ord_err == o0,
          lens[li] == 255 ? "R5 R10" : "R5", wr_cnt - w0, lens[li]);
      @(negedge clk);
      np = 0;
      for (int i = 0; i < 256; i++) begin
        av = mem[256 + i]; bv = mem[i];
        if (bv != 24'(13 * i + 5)) np++;
        if (i < lens[li] ? av != 24'(13 * i + 5) : av != 24'hABCDEF) np++;
      end
      chk(np == 0, "R5", np, 0);
    end
    // R6 clear
    lens = '{1, 9, 255, 3};
    for (int li = 0; li < 4; li++) begin
      for (int i = 0; i < 256; i++) poke(256 + i, 24'h5A5A5A);
      run(2'd3, 7, 256, lens[li], 24'h0, cyc);
      chk(done && flags() == 3'b000 && rd_cnt == r0 && wr_cnt - w0 == lens[li],
          lens[li] == 255 ? "R6 R10" : "R6", wr_cnt - w0, lens[li]);
      @(negedge clk);
      np = 0;
      for (int i = 0; i < 256; i++)
        if (mem[256 + i] != (i < lens[li] ? 24'h0 : 24'h5A5A5A)) np++;
      chk(np == 0 && ord_err == o0, "R6", np, 0);
    end
    // R8 start while busy ignored
    for (int i = 0; i < 10; i++) begin poke(i, 24'(i + 40)); poke(256 + i, 24'(i + 40)); end
    @(negedge clk);
    d0 = done_cnt; r0 = rd_cnt; w0 = wr_cnt;
    op = 2'd0; addr_a = 15'd0; addr_b = 15'd256; len = 8'd10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    op = 2'd3; len = 8'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(flags() == 3'b010 && !err, "R8", flags(), 2);
    repeat (4) @(negedge clk);
    chk(done_cnt - d0 == 1 && wr_cnt == w0 && mem[256] == 24'd40, "R8", done_cnt - d0, 1);
    chk(!done && !busy, "R9", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !err && flags() == 3'b000, "R9", busy, 0);
    rst_n = 1'b1;
    full_gnt = 1'b1;
    suite();
    full_gnt = 1'b0;
    suite();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule